// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host processor on a simple 32-bit register bus access to configuration space through two registers. The host first writes a selector register that holds an enable flag and the bus, device, function and dword-register fields of the target. It then reads or writes a data window. The data access uses whatever selector is latched at that moment, so the same selector can serve several data accesses in a row.

Data-window accesses take one of two routes. If the selector names bus 0, device 0, function 0, the access is served at once from a small local register file that holds the bridge's own settings. These are a control word and a set of memory-window descriptors. Any other target goes out on a request/response downstream port as a configuration cycle. The register bus is stalled with ready held low until that cycle completes, fails, or times out.

Byte and halfword accesses are supported. The two low bits of the window address pick the byte lane. Write data arrives right-justified and the port steers it into the lane. Read data is shifted down and masked to the access size before it is returned.

Top module: `cfg_access_port`

## Requirements
- R1: A write to byte offset 0x28 latches the selector: enable at bit 31, bus at bits 23..16, device at bits 15..11, function at bits 10..8 and dword register at bits 7..2. A read of 0x28 returns the latched value with all other bits zero. The selector is zero after reset.
- R2: The data window is byte offsets 0x2C..0x2F, and reg_addr[1:0] is the byte lane. Size code 0 is byte, 1 is halfword, and 2 or 3 is word; a word access ignores the lane. Write data is taken from the low bits of reg_wdata and shifted left by 8 times the lane. Byte enables are 0001 for a byte or 0011 for a halfword, shifted left by the lane and clipped to 4 bits, or 1111 for a word.
- R3: A window read returns the target dword shifted right by 8 times the lane, then masked to 8 or 16 bits for a byte or halfword access.
- R4: While the enable bit is clear, a window read returns all ones masked to the access size. A window write changes nothing, and no downstream request is made.
- R5: With enable set and the selector at bus 0, device 0, function 0, the access is served by the local file with reg_ready high in the same cycle and no downstream request. Any non-zero bus, device or function goes downstream.
- R6: In the local file, dword 0x13 (byte 0x4C) is a 32-bit control register written per byte lane. NUM_WIN window registers from dword 0x14 (0x50, 0x54, 0x58) keep only bits 31..16, and bits 15..0 read zero. Every other local dword reads zero and ignores writes. All registers reset to zero.
- R7: Any other enabled window access raises dn_req with the latched bus, device, function and dword, dn_wr, the byte enables and the lane-placed write data. All of these are held stable until dn_ack or dn_err.
- R8: reg_ready stays low from the start of a downstream access until the response. It then rises for one cycle, one clock after the cycle in which dn_ack was sampled, carrying the read data.
- R9: A dn_err response, or no response within TIMEOUT cycles of waiting, withdraws the request and returns all ones masked to the access size.
- R10: A register-bus access to any offset other than the selector and the window reads zero, ignores writes and completes with reg_ready high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register-bus access request, held until reg_ready |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset in the register space |
| reg_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reg_wdata | input | 32 | Write data, right-justified for sub-word accesses |
| reg_rdata | output | 32 | Read data, right-justified and masked |
| reg_ready | output | 1 | Access completes in this cycle |
| dn_req | output | 1 | Downstream configuration cycle pending |
| dn_wr | output | 1 | Downstream cycle is a write |
| dn_bus | output | 8 | Target bus number |
| dn_dev | output | 5 | Target device number |
| dn_fn | output | 3 | Target function number |
| dn_dw | output | 6 | Target dword register index |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_ack | input | 1 | Target completed the cycle |
| dn_err | input | 1 | Target reported an error |
| dn_rdata | input | 32 | Read data from the target, valid with dn_ack |

## Verification
The bench goes after lane steering at every lane for byte and halfword accesses, in both directions. A wrong shift or enable would corrupt a neighbouring byte of the local control word or return the wrong downstream byte. It sweeps every local dword. A decoder that aliased the window registers, or kept their low halves, would show non-zero readback where zero is due. It also probes the routing boundary, where bus 0 with device 1 must go downstream and bus 0, device 0, function 0 must not. The bench times the stall for each response latency and for the timeout. A port that released ready early, or hung on a silent target, would give the wrong stall count or trip the watchdog. Finally, it clears the enable bit and checks that a write leaves the local register untouched.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } dn_state_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_sel_t;

  localparam logic [31:0] SEL_KEEP = 32'h80FF_FFFC;

  function automatic logic [3:0] lane_be(input logic [1:0] size, input logic [1:0] lane);
    logic [6:0] wide;
    case (size)
      2'd0:    wide = 7'b000_0001 << lane;
      2'd1:    wide = 7'b000_0011 << lane;
      default: wide = 7'b000_1111;
    endcase
    return wide[3:0];
  endfunction

  function automatic logic [31:0] lane_place(input logic [31:0] data, input logic [1:0] size,
                                             input logic [1:0] lane);
    if (size[1]) return data;
    return data << {lane, 3'b000};
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] dword, input logic [1:0] size,
                                            input logic [1:0] lane);
    logic [31:0] sh;
    sh = dword >> {lane, 3'b000};
    case (size)
      2'd0:    return {24'd0, sh[7:0]};
      2'd1:    return {16'd0, sh[15:0]};
      default: return dword;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_sel_reg.sv
module cfgp_sel_reg
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output cfg_sel_t    sel,
  output logic [31:0] rdword
);

  cfg_sel_t sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) begin
      sel_d.en  = wdata[31];
      sel_d.bus = wdata[23:16];
      sel_d.dev = wdata[15:11];
      sel_d.fn  = wdata[10:8];
      sel_d.dw  = wdata[7:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_en) sel_q <= sel_d;
  end

  assign sel    = sel_q;
  assign rdword = {sel_q.en, 7'd0, sel_q.bus, sel_q.dev, sel_q.fn, sel_q.dw, 2'b00};

  assert_sel_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdword == ($past(wdata) & SEL_KEEP)));

endmodule

// File: rtl/cfgp_local_file.sv
module cfgp_local_file
  import cfgp_pkg::*;
#(
  parameter int          NUM_WIN  = 3,
  parameter logic [5:0]  CTRL_DW  = 6'h13,
  parameter logic [5:0]  WIN_DW   = 6'h14,
  parameter logic [31:0] WIN_KEEP = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  dw,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam int NREG = 1 + NUM_WIN;

  logic [31:0] regs_q [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [5:0]  MY_DW   = (g == 0) ? CTRL_DW : 6'(WIN_DW + 6'(g - 1));
    localparam logic [31:0] MY_KEEP = (g == 0) ? 32'hFFFF_FFFF : WIN_KEEP;
    logic [31:0] bmask, nxt;

    assign hit[g] = (dw == MY_DW);
    assign bmask  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};

    always_comb begin
      nxt = ((regs_q[g] & ~bmask) | (wdata & bmask)) & MY_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (wr_en && hit[g]) regs_q[g] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = rdata | regs_q[i];
    end
  end

  assert_one_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/cfgp_dn_port.sv
module cfgp_dn_port
  import cfgp_pkg::*;
#(
  parameter int TIMEOUT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  cfg_sel_t    sel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        idle,
  output logic        done,
  output logic [31:0] resp,
  output logic        dn_req,
  output logic        dn_wr,
  output logic [7:0]  dn_bus,
  output logic [4:0]  dn_dev,
  output logic [2:0]  dn_fn,
  output logic [5:0]  dn_dw,
  output logic [3:0]  dn_be,
  output logic [31:0] dn_wdata,
  input  logic        dn_ack,
  input  logic        dn_err,
  input  logic [31:0] dn_rdata
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  dn_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      resp_q, resp_d;
  logic             load;
  logic             tmo_hit;

  assign tmo_hit = (cnt_q == CNT_LAST);
  assign load    = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    resp_d = resp_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      end
      ST_WAIT: begin
        if (dn_ack || dn_err) begin
          resp_d = dn_err ? 32'hFFFF_FFFF : dn_rdata;
          st_d   = ST_RESP;
        end else if (tmo_hit) begin
          resp_d = 32'hFFFF_FFFF;
          st_d   = ST_RESP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      resp_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      resp_q <= resp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_wr    <= 1'b0;
      dn_bus   <= '0;
      dn_dev   <= '0;
      dn_fn    <= '0;
      dn_dw    <= '0;
      dn_be    <= '0;
      dn_wdata <= '0;
    end else if (load) begin
      dn_wr    <= wr;
      dn_bus   <= sel.bus;
      dn_dev   <= sel.dev;
      dn_fn    <= sel.fn;
      dn_dw    <= sel.dw;
      dn_be    <= be;
      dn_wdata <= wdata;
    end
  end

  assign dn_req = (st_q == ST_WAIT);
  assign idle   = (st_q == ST_IDLE);
  assign done   = (st_q == ST_RESP);
  assign resp   = resp_q;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack && !dn_err && !tmo_hit) |=>
      (dn_req && $stable(dn_bus) && $stable(dn_dev) && $stable(dn_fn) &&
       $stable(dn_dw) && $stable(dn_be) && $stable(dn_wdata) && $stable(dn_wr)));

  assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (cnt_q <= CNT_LAST));

  assert_tmo_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && tmo_hit) |=> !dn_req);

endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_WIN  = 3,
  parameter int          TIMEOUT  = 32,
  parameter logic [7:0]  SEL_OFF  = 8'h28,
  parameter logic [7:0]  WIN_OFF  = 8'h2C,
  parameter logic [5:0]  CTRL_DW  = 6'h13,
  parameter logic [5:0]  WIN_DW   = 6'h14,
  parameter logic [31:0] WIN_KEEP = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_ready,
  output logic              dn_req,
  output logic              dn_wr,
  output logic [7:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_fn,
  output logic [5:0]        dn_dw,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [31:0]       dn_rdata
);

  localparam int DW_HI = ADDR_W - 1;
  localparam logic [ADDR_W-3:0] SEL_IDX = SEL_OFF[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] WIN_IDX = WIN_OFF[ADDR_W-1:2];

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cfg_sel_t    sel;
  logic [31:0] sel_rdword;
  logic        sel_hit, win_hit, local_hit, dn_target;
  logic [1:0]  lane;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic        fsm_idle, fsm_done;
  logic [31:0] fsm_resp;
  logic [31:0] loc_rdata;
  logic        sel_we, loc_we, launch;

  assign sel_hit   = (reg_addr[DW_HI:2] == SEL_IDX);
  assign win_hit   = (reg_addr[DW_HI:2] == WIN_IDX);
  assign lane      = reg_addr[1:0];
  assign local_hit = (sel.bus == 8'd0) && (sel.dev == 5'd0) && (sel.fn == 3'd0);
  assign dn_target = sel.en && !local_hit;
  assign acc_be    = lane_be(reg_size, lane);
  assign acc_wdata = lane_place(reg_wdata, reg_size, lane);

  assign sel_we = reg_sel && reg_wr && sel_hit && fsm_idle;
  assign loc_we = reg_sel && reg_wr && win_hit && sel.en && local_hit && fsm_idle;
  assign launch = reg_sel && win_hit && dn_target && fsm_idle;

  cfgp_sel_reg u_sel (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (sel_we),
    .wdata  (reg_wdata),
    .sel    (sel),
    .rdword (sel_rdword)
  );

  cfgp_local_file #(
    .NUM_WIN  (NUM_WIN),
    .CTRL_DW  (CTRL_DW),
    .WIN_DW   (WIN_DW),
    .WIN_KEEP (WIN_KEEP)
  ) u_local (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (loc_we),
    .dw    (sel.dw),
    .be    (acc_be),
    .wdata (acc_wdata),
    .rdata (loc_rdata)
  );

  cfgp_dn_port #(
    .TIMEOUT (TIMEOUT)
  ) u_dn (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (launch),
    .wr       (reg_wr),
    .sel      (sel),
    .be       (acc_be),
    .wdata    (acc_wdata),
    .idle     (fsm_idle),
    .done     (fsm_done),
    .resp     (fsm_resp),
    .dn_req   (dn_req),
    .dn_wr    (dn_wr),
    .dn_bus   (dn_bus),
    .dn_dev   (dn_dev),
    .dn_fn    (dn_fn),
    .dn_dw    (dn_dw),
    .dn_be    (dn_be),
    .dn_wdata (dn_wdata),
    .dn_ack   (dn_ack),
    .dn_err   (dn_err),
    .dn_rdata (dn_rdata)
  );

  always_comb begin
    reg_ready = fsm_done || (reg_sel && fsm_idle && !launch);
    reg_rdata = '0;
    if (fsm_done) begin
      reg_rdata = lane_pick(fsm_resp, reg_size, lane);
    end else if (sel_hit) begin
      reg_rdata = sel_rdword;
    end else if (win_hit) begin
      if (!sel.en)        reg_rdata = lane_pick(32'hFFFF_FFFF, reg_size, lane);
      else if (local_hit) reg_rdata = lane_pick(loc_rdata, reg_size, lane);
    end
  end

  assert_wait_stall_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    dn_req |-> !reg_ready);

  assert_no_self_out_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    dn_req |-> !((dn_bus == 8'd0) && (dn_dev == 5'd0) && (dn_fn == 3'd0)));

  assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (launch && (reg_size == 2'd0)) |=> ($countones(dn_be) == 1));

  assert_ready_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dn_req && dn_ack) |=> (reg_ready && !dn_req));

  assert_off_no_out_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fsm_idle && reg_sel && win_hit && !sel.en) |=> !dn_req);

endmodule

// File: tb/test_cfg_access_port.sv
`timescale 1ns/1ps
module test_cfg_access_port;

  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready;
  logic        dn_req, dn_wr;
  logic [7:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [5:0]  dn_dw;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0, dn_err = 1'b0;
  logic [31:0] dn_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  cfg_access_port #(.TIMEOUT(TMO)) i_cfg_access_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_bus(dn_bus), .dn_dev(dn_dev), .dn_fn(dn_fn),
    .dn_dw(dn_dw), .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err),
    .dn_rdata(dn_rdata)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [7:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] w);
    return {w, 2'b01, f, d, b, 8'hA5};
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] v, input int sz, input int ln);
    logic [31:0] s;
    s = v >> (8 * ln);
    if (sz == 0) return s & 32'hFF;
    if (sz == 1) return s & 32'hFFFF;
    return v;
  endfunction

  // downstream target model: dev 31 silent, dev 30 errors, latency dev%3
  int lat_cnt = 0, dn_count = 0;
  logic        cap_wr;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [5:0]  cap_dw;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  initial begin
    forever begin
      @(negedge clk);
      if (dn_ack || dn_err) begin
        dn_ack = 0; dn_err = 0; lat_cnt = 0;
      end else if (!dn_req) begin
        lat_cnt = 0;
      end else if (dn_dev != 5'd31) begin
        if (lat_cnt == int'(dn_dev) % 3) begin
          dn_count++;
          cap_wr = dn_wr; cap_bus = dn_bus; cap_dev = dn_dev; cap_fn = dn_fn;
          cap_dw = dn_dw; cap_be = dn_be; cap_wdata = dn_wdata;
          dn_rdata = pat(dn_bus, dn_dev, dn_fn, dn_dw);
          if (dn_dev == 5'd30) dn_err = 1; else dn_ack = 1;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input int sz, input logic [31:0] wd,
                      output logic [31:0] rd, output int stalls);
    @(negedge clk);
    reg_sel = 1; reg_wr = wr; reg_addr = a; reg_size = 2'(sz); reg_wdata = wd; stalls = 0;
    #1;
    while (!reg_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic point(input bit en, input int b, input int d, input int f, input int w);
    logic [31:0] rd;
    int st;
    xfer(1, 8'h28, 2, {en, 7'd0, 8'(b), 5'(d), 3'(f), 6'(w), 2'b00}, rd, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp;
    logic [31:0] loc [64];
    int st, base;

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    xfer(0, 8'h28, 2, 0, rd, st);
    check("R1 reset selector", rd, 32'h0);
    check("R7 reset dn_req", {31'd0, dn_req}, 32'h0);

    // R1 selector latch and mask
    foreach (loc[i]) loc[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin
      exp = 32'h9E37_79B9 * (i + 3);
      xfer(1, 8'h28, 2, exp, rd, st);
      xfer(0, 8'h28, 2, 0, rd, st);
      check("R1 selector readback", rd, exp & 32'h80FF_FFFC);
    end

    // R6 local file sweep over all dwords, R5 same-cycle ready
    base = dn_count;
    for (int w = 0; w < 64; w++) begin
      point(1, 0, 0, 0, w);
      exp = 32'h9E37_79B9 * (w + 1);
      xfer(1, 8'h2C, 2, exp, rd, st);
      if (w == 6'h13) loc[w] = exp;
      else if (w >= 6'h14 && w <= 6'h16) loc[w] = exp & 32'hFFFF_0000;
    end
    for (int w = 0; w < 64; w++) begin
      point(1, 0, 0, 0, w);
      xfer(0, 8'h2C, 2, 0, rd, st);
      check("R6 local readback", rd, loc[w]);
      if (w == 0) check("R5 local no stall", st, 0);
    end
    check("R5 no downstream for own function", dn_count - base, 0);

    // R2/R3 byte lanes on control register
    point(1, 0, 0, 0, 6'h13);
    for (int ln = 0; ln < 4; ln++) begin
      xfer(1, 8'(8'h2C + ln), 0, 32'h10 + ln, rd, st);
      loc[6'h13] = (loc[6'h13] & ~(32'hFF << (8 * ln))) | ((32'h10 + ln) << (8 * ln));
    end
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R2 byte lane writes", rd, loc[6'h13]);
    for (int ln = 0; ln < 4; ln++) begin
      xfer(0, 8'(8'h2C + ln), 0, 0, rd, st);
      check("R3 byte lane read", rd, pick(loc[6'h13], 0, ln));
    end
    for (int ln = 0; ln < 3; ln++) begin
      xfer(0, 8'(8'h2C + ln), 1, 0, rd, st);
      check("R3 half lane read", rd, pick(loc[6'h13], 1, ln));
    end
    xfer(1, 8'h2E, 1, 32'hFFFF_BEEF, rd, st);
    loc[6'h13] = (loc[6'h13] & 32'h0000_FFFF) | 32'hBEEF_0000;
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R2 half write upper", rd, loc[6'h13]);

    // R4 enable clear
    point(0, 0, 0, 0, 6'h13);
    xfer(1, 8'h2C, 2, 32'h1234_5678, rd, st);
    xfer(0, 8'h2D, 0, 0, rd, st);
    check("R4 disabled byte read", rd, 32'hFF);
    xfer(0, 8'h2C, 1, 0, rd, st);
    check("R4 disabled half read", rd, 32'hFFFF);
    base = dn_count;
    point(0, 3, 1, 0, 0);
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R4 disabled word read", rd, 32'hFFFF_FFFF);
    check("R4 disabled no downstream", dn_count - base, 0);
    point(1, 0, 0, 0, 6'h13);
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R4 write dropped", rd, loc[6'h13]);

    // R7/R3/R8 downstream read sweep
    for (int b = 1; b < 3; b++)
      for (int d = 0; d < 8; d++)
        for (int f = 0; f < 8; f++) begin
          point(1, b * 127 - 126, d, f, d + f);
          xfer(0, 8'h2C, 2, 0, rd, st);
          check("R7 downstream read", rd, pat(8'(b * 127 - 126), 5'(d), 3'(f), 6'(d + f)));
          if (f == 0) check("R8 stall cycles", st, 2 + d % 3);
        end

    // R5 boundary: bus 0 device 1 goes out
    base = dn_count;
    point(1, 0, 1, 0, 5);
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R5 bus0 dev1 downstream", dn_count - base, 1);
    check("R5 bus0 dev1 data", rd, pat(0, 1, 0, 5));

    // R3 sub-word downstream reads
    point(1, 4, 2, 5, 9);
    for (int ln = 0; ln < 4; ln++) begin
      xfer(0, 8'(8'h2C + ln), 0, 0, rd, st);
      check("R3 downstream byte", rd, pick(pat(4, 2, 5, 9), 0, ln));
      xfer(0, 8'(8'h2C + ln), 1, 0, rd, st);
      check("R3 downstream half", rd, pick(pat(4, 2, 5, 9), 1, ln));
    end

    // R2/R7 downstream writes
    for (int ln = 0; ln < 4; ln++) begin
      point(1, 7, 3, 1, 12 + ln);
      xfer(1, 8'(8'h2C + ln), 0, 32'hAB, rd, st);
      check("R7 write flag", {31'd0, cap_wr}, 1);
      check("R7 write target", {cap_bus, 3'd0, cap_dev, 5'd0, cap_fn, 2'd0, cap_dw},
            {8'd7, 3'd0, 5'd3, 5'd0, 3'd1, 2'd0, 6'(12 + ln)});
      check("R2 byte enables", {28'd0, cap_be}, 32'(4'b0001 << ln));
      check("R2 placed data", cap_wdata, 32'hAB << (8 * ln));
    end
    xfer(1, 8'h2F, 1, 32'hBBCD, rd, st);
    check("R2 clipped half be", {28'd0, cap_be}, 32'h8);
    check("R2 clipped half data", cap_wdata, 32'hCD00_0000);
    xfer(1, 8'h2C, 2, 32'hCAFE_F00D, rd, st);
    check("R2 word be", {28'd0, cap_be}, 32'hF);
    check("R2 word data", cap_wdata, 32'hCAFE_F00D);

    // R9 error and timeout
    point(1, 2, 30, 0, 1);
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R9 error word", rd, 32'hFFFF_FFFF);
    xfer(0, 8'h2E, 1, 0, rd, st);
    check("R9 error half", rd, 32'hFFFF);
    point(1, 2, 31, 0, 1);
    xfer(0, 8'h2C, 2, 0, rd, st);
    check("R9 timeout data", rd, 32'hFFFF_FFFF);
    check("R9 timeout stall", st, TMO + 1);
    xfer(0, 8'h2D, 0, 0, rd, st);
    check("R9 timeout byte", rd, 32'hFF);
    check("R9 request withdrawn", {31'd0, dn_req}, 0);

    // R10 other offsets
    xfer(1, 8'h10, 2, 32'h5555_AAAA, rd, st);
    xfer(0, 8'h10, 2, 0, rd, st);
    check("R10 unmapped read", rd, 0);
    check("R10 no stall", st, 0);
    xfer(0, 8'h28, 2, 0, rd, st);
    check("R10 selector untouched", rd, {1'b1, 7'd0, 8'd2, 5'd31, 3'd0, 6'd1, 2'b00});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule